// File: doc/BRIEF.md
# Stochastic Bitstream Multiplier and Half-Adder

This block does unsigned arithmetic on values in the range [0,1] coded as the probability that a bit of a single-wire stream is one. Each W-bit operand is turned into a stream by an encoder. The encoder compares the operand with the state of its own maximal-length LFSR and emits a one whenever the operand is the larger. The two operand encoders use reciprocal feedback polynomials, so their streams are nearly uncorrelated.

A single gate level combines the streams. In product mode it is an AND. In half-sum mode it is (x AND y) OR ((x OR y) AND r), where r is a helper stream with probability one half. r is the parity of a third LFSR. A decoder counts the ones of the combined stream over a window of 2^W clocks. That count, limited to all ones, is the W-bit result.

A caller raises `start_i` with both operands and the mode. The operands are captured on the accepting edge. `valid_o` pulses once when the window closes. Reset reloads every LFSR seed, so a given sequence of operations always yields the same results.

Top module: `sc_arith_unit`

## Requirements
- R1: After reset `valid_o` is 0 and `result_o` is 0.
- R2: An encoder emits 1 exactly when its operand, as an unsigned number, is greater than its LFSR value. A zero operand therefore gives an all-zero stream: a product with a zero operand, and a half-sum of two zeros, return exactly 0.
- R3: With `mode_i`=0 (product), `result_o` is within 2^W/8 of floor(a*b/2^W).
- R4: With `mode_i`=1 (half-sum), `result_o` is within 2^W/8 of floor((a+b)/2).
- R5: `valid_o` is high for exactly one cycle. It rises on the 2^W+1-th rising edge, counting the edge that accepted `start_i` as the first.
- R6: A `start_i` raised while a window is running is ignored. The result and its timing belong to the operation already accepted.
- R7: The ones count never exceeds the number of stream bits seen. A count of 2^W is returned as all ones, and a full-scale product does not wrap to a small value.
- R8: Reset reloads all LFSR seeds, so the same operation issued first after two resets returns identical results.
- R9: The two operand streams are nearly uncorrelated. The product of a=b=2^(W-1) lands within 2^W/8 of 2^W/4, and not near 2^W/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation; taken only when idle |
| mode_i | input | 1 | 0 = product, 1 = half-sum |
| a_i | input | W | Operand a, value a/2^W |
| b_i | input | W | Operand b, value b/2^W |
| valid_o | output | 1 | One-cycle pulse when the result is ready |
| result_o | output | W | Ones count of the window, saturated |

## Verification
The bench goes after the exact corners: zero operands must give exactly 0, and a design that compares with greater-or-equal, or lets the helper stream leak in, returns a non-zero value. A start issued in the middle of a window must change neither the zero result nor the 2^W+1 latency; a design that re-arms would give a large value or a late pulse. Full-scale operands must stay near the top rather than wrap, and a swapped mode decode turns 255×0 into about 127. Equal operands of one half expose correlated generators, which give about one half instead of one quarter. A repeated run after reset exposes seeds that are not reloaded.

// File: rtl/sc_arith_pkg.sv
package sc_arith_pkg;

  typedef enum logic {
    OP_MUL      = 1'b0,
    OP_HALF_ADD = 1'b1
  } sc_op_e;

  // Right-shift Galois masks for maximal-length sequences; bit i stands for x^(i+1).
  function automatic logic [15:0] lfsr_mask(input int unsigned w);
    case (w)
      4:       return 16'h0009;
      5:       return 16'h0012;
      6:       return 16'h0021;
      7:       return 16'h0041;
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0E08;
      13:      return 16'h1C80;
      14:      return 16'h3802;
      15:      return 16'h6000;
      default: return 16'hB400;
    endcase
  endfunction

  // Mask of the reciprocal polynomial, also maximal length.
  function automatic logic [15:0] recip_mask(input int unsigned w, input logic [15:0] m);
    logic [15:0] r;
    r = '0;
    r[w-1] = 1'b1;
    for (int i = 0; i < int'(w) - 1; i++) begin
      if (m[i]) r[int'(w) - 2 - i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/sc_lfsr.sv
module sc_lfsr #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SEED = W'(1),
  parameter logic [W-1:0] MASK = W'(8'hB8)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     st_q <= SEED;
    else if (step_i) st_q <= (st_q >> 1) ^ (st_q[0] ? MASK : '0);
  end

  assign state_o = st_q;

  // R8: a seeded register never falls into the all-zero lock-up state
  a_r8_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q != '0);
endmodule

// File: rtl/sc_encoder.sv
module sc_encoder #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SEED = W'(1),
  parameter logic [W-1:0] MASK = W'(8'hB8)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  input  logic [W-1:0] operand_i,
  output logic         bit_o
);
  logic [W-1:0] rnd;

  sc_lfsr #(.W(W), .SEED(SEED), .MASK(MASK)) u_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .state_o (rnd)
  );

  assign bit_o = operand_i > rnd;

  // R2: zero operand yields a silent stream
  a_r2_zero_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (operand_i == '0) |-> !bit_o);
endmodule

// File: rtl/sc_decoder.sv
module sc_decoder #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clear_i,
  input  logic         en_i,
  input  logic         bit_i,
  output logic         last_o,
  output logic         done_o,
  output logic [W-1:0] value_o
);
  logic [W-1:0] win_q;
  logic [W:0]   ones_q;
  logic [W:0]   ones_nxt;
  logic         done_q;
  logic [W-1:0] value_q;

  assign ones_nxt = ones_q + (W+1)'(bit_i);
  assign last_o   = en_i && (win_q == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      ones_q <= '0;
    end else if (clear_i) begin
      win_q  <= '0;
      ones_q <= '0;
    end else if (en_i) begin
      win_q  <= win_q + W'(1);
      ones_q <= ones_nxt;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      value_q <= '0;
    end else begin
      done_q <= last_o;
      if (last_o) value_q <= ones_nxt[W] ? '1 : ones_nxt[W-1:0];
    end
  end

  assign done_o  = done_q;
  assign value_o = value_q;

  // R7: ones counted never exceed bits seen within the window
  a_r7_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (ones_q <= {1'b0, win_q}));
endmodule

// File: rtl/sc_arith_unit.sv
module sc_arith_unit
  import sc_arith_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] SEED_A = W'(8'h5D),
  parameter logic [W-1:0] SEED_B = W'(8'h2B),
  parameter logic [W-1:0] SEED_R = W'(8'h91)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         mode_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         valid_o,
  output logic [W-1:0] result_o
);
  localparam logic [W-1:0] MASK_A = W'(lfsr_mask(W));
  localparam logic [W-1:0] MASK_B = W'(recip_mask(W, lfsr_mask(W)));
  localparam int unsigned  NSRC   = 2;

  logic         busy_q;
  logic [W-1:0] opnd_q [NSRC];
  sc_op_e       mode_q;
  logic [NSRC-1:0] strm;
  logic [W-1:0] rnd_r;
  logic         help_bit;
  logic         z_bit;
  logic         accept;
  logic         win_end;

  assign accept = start_i && !busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      opnd_q[0] <= '0;
      opnd_q[1] <= '0;
      mode_q    <= OP_MUL;
    end else if (accept) begin
      busy_q    <= 1'b1;
      opnd_q[0] <= a_i;
      opnd_q[1] <= b_i;
      mode_q    <= sc_op_e'(mode_i);
    end else if (win_end) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam logic [W-1:0] SD = (g == 0) ? SEED_A : SEED_B;
    localparam logic [W-1:0] MK = (g == 0) ? MASK_A : MASK_B;
    sc_encoder #(.W(W), .SEED(SD), .MASK(MK)) u_enc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .step_i    (busy_q),
      .operand_i (opnd_q[g]),
      .bit_o     (strm[g])
    );
  end

  sc_lfsr #(.W(W), .SEED(SEED_R), .MASK(MASK_A)) u_help (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (busy_q),
    .state_o (rnd_r)
  );

  // parity of a nonzero state is one in 2^(W-1) of 2^W-1 states
  assign help_bit = ^rnd_r;

  always_comb begin
    if (mode_q == OP_MUL) z_bit = strm[0] & strm[1];
    else                  z_bit = (strm[0] & strm[1]) | ((strm[0] | strm[1]) & help_bit);
  end

  sc_decoder #(.W(W)) u_dec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .en_i    (busy_q),
    .bit_i   (z_bit),
    .last_o  (win_end),
    .done_o  (valid_o),
    .value_o (result_o)
  );

  // R5: result strobe lasts one cycle
  a_r5_valid_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  // R5: strobe follows the end of a running window
  a_r5_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> !busy_q);
  // R6: operands are frozen while a window runs
  a_r6_hold_operands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && start_i) |=> ($stable(opnd_q[0]) && $stable(opnd_q[1]) && $stable(mode_q)));
  // R2: product of a zero operand never produces a one
  a_r2_mul_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && mode_q == OP_MUL && (opnd_q[0] == '0 || opnd_q[1] == '0)) |-> !z_bit);
endmodule

// File: tb/sc_arith_unit_bench.sv
module sc_arith_unit_bench;
  localparam int W    = 8;
  localparam int FULL = 1 << W;
  localparam int TOL  = FULL / 8;
  localparam int LAT  = FULL + 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         mode = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         valid;
  logic [W-1:0] result;

  int checks = 0;
  int fails  = 0;

  always #10ns clk = ~clk;

  sc_arith_unit #(.W(W)) u_sc_arith_unit (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .mode_i   (mode),
    .a_i      (a),
    .b_i      (b),
    .valid_o  (valid),
    .result_o (result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Issue one operation; returns result and negedges from start to valid.
  task automatic run_op(input int av, input int bv, input bit md,
                        output int res, output int lat);
    @(negedge clk);
    a = W'(av); b = W'(bv); mode = md; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!valid && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    res = int'(result);
    if (!valid) check(1'b0, "timeout", lat, LAT);
  endtask

  function automatic int absd(input int x, input int y);
    return (x > y) ? x - y : y - x;
  endfunction

  task automatic t_reset_state();
    do_reset();
    check(valid == 1'b0, "R1 valid", int'(valid), 0);
    check(result == '0, "R1 result", int'(result), 0);
  endtask

  task automatic t_zero_exact();
    int r, l;
    run_op(0, 200, 1'b0, r, l);
    check(r == 0, "R2 mul a=0", r, 0);
    run_op(255, 0, 1'b0, r, l);
    check(r == 0, "R2 mul b=0", r, 0);
    run_op(0, 0, 1'b1, r, l);
    check(r == 0, "R2 add 0+0", r, 0);
  endtask

  task automatic t_mul();
    int av[5] = '{255, 128, 200, 64, 17};
    int bv[5] = '{255, 64, 100, 192, 240};
    int r, l, e;
    for (int i = 0; i < 5; i++) begin
      run_op(av[i], bv[i], 1'b0, r, l);
      e = (av[i] * bv[i]) / FULL;
      check(absd(r, e) <= TOL, "R3 product", r, e);
    end
  endtask

  task automatic t_add();
    int av[4] = '{255, 100, 255, 10};
    int bv[4] = '{0, 60, 255, 200};
    int r, l, e;
    for (int i = 0; i < 4; i++) begin
      run_op(av[i], bv[i], 1'b1, r, l);
      e = (av[i] + bv[i]) / 2;
      check(absd(r, e) <= TOL, "R4 half-sum", r, e);
    end
  endtask

  task automatic t_latency();
    int r, l;
    run_op(90, 90, 1'b0, r, l);
    check(l == LAT, "R5 latency", l, LAT);
    @(negedge clk);
    check(valid == 1'b0, "R5 one-cycle pulse", int'(valid), 0);
  endtask

  task automatic t_busy_ignore();
    int lat;
    @(negedge clk);
    a = '0; b = 8'd77; mode = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    repeat (49) begin @(negedge clk); lat++; end
    a = '1; b = '1; mode = 1'b1; start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!valid && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    check(lat == LAT, "R6 latency unchanged", lat, LAT);
    check(result == '0, "R6 result of first op", int'(result), 0);
    repeat (2 * LAT) @(negedge clk);
    check(valid == 1'b0, "R6 no second strobe", int'(valid), 0);
  endtask

  task automatic t_full_scale();
    int r, l;
    run_op(255, 255, 1'b0, r, l);
    check(r >= FULL - 1 - TOL, "R7 full-scale product no wrap", r, FULL - 1);
    run_op(255, 255, 1'b1, r, l);
    check(r >= FULL - 1 - TOL, "R7 full-scale half-sum no wrap", r, FULL - 1);
  endtask

  task automatic t_repeat();
    int r1, r2, l;
    do_reset();
    run_op(200, 150, 1'b0, r1, l);
    do_reset();
    run_op(200, 150, 1'b0, r2, l);
    check(r1 == r2, "R8 repeatable after reset", r2, r1);
    do_reset();
    run_op(40, 180, 1'b1, r1, l);
    do_reset();
    run_op(40, 180, 1'b1, r2, l);
    check(r1 == r2, "R8 repeatable half-sum", r2, r1);
  endtask

  task automatic t_independent();
    int r, l;
    run_op(FULL / 2, FULL / 2, 1'b0, r, l);
    check(absd(r, FULL / 4) <= TOL, "R9 uncorrelated streams", r, FULL / 4);
  endtask

  initial begin
    t_reset_state();
    t_zero_exact();
    t_mul();
    t_add();
    t_latency();
    t_busy_ignore();
    t_full_scale();
    t_independent();
    t_repeat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule